// File: doc/BRIEF.md
# General-Purpose I/O Bank with Input Hold and Edge Wakeup

This block controls a bank of general-purpose pins. Every pin has a direction bit and an output level, and an alternate-function select that hands the pin to a peripheral signal. Rising-edge and falling-edge enables feed sticky status flags. The pads are modelled as separate input, output and output-enable vectors. A small word-addressed register port with a combinational read path carries all configuration and status.

After either reset every pin is a GPIO input and the input path is held: the level register reads zero and no edges are recorded until software clears the hold bit. The intended bring-up order is direction first, then hold release, then alternate-function selection. A hard reset also leaves the two lowest pins armed for both edges, so they can act as wakeup sources from power-up. The `wake_o` output is high whenever an enabled edge flag is set. The two lowest pins have no alternate function.

Top module: `gpio_bank`

## Requirements
- R1: After hard reset (`rst_ni` low): output enables are 0, the output register is 0, the alternate select is 0, the hold bit (CTRL bit 0, address 10) reads 1, and the rising-edge (address 5) and falling-edge (address 6) enables read 0x03.
- R2: A one-cycle `soft_rst_i` pulse restores the R1 state, except that both edge-enable registers read 0. Edge status is cleared as well.
- R3: When a pin is not in alternate mode, `gpio_oe_o` follows the direction register (address 0, 1 = output) and `gpio_o` follows the output register (address 1). A write to address 2 sets the output bits that are 1 in the data. A write to address 3 clears them. Bits written as 0 keep their value.
- R4: Address 4 returns each pin's input through a two-flop synchronizer. While the hold bit is 1 it returns 0.
- R5: Clearing the hold bit while the pins are static records no edge.
- R6: With hold clear and the rising enable set, a 0-to-1 input transition sets that pin's bit in the rising status (address 8). The bit stays set until a write of 1 to that bit. Writing 0 has no effect.
- R7: The falling status (address 9) behaves in the same way for 1-to-0 transitions under the falling enable.
- R8: No status bit is set while the hold bit is 1, or for a pin whose enable for that edge is 0.
- R9: With a pin's alternate bit (address 7) set, `gpio_o` and `gpio_oe_o` for that pin come from `alt_out_i` and `alt_oe_i`, and `alt_in_o` carries `gpio_i`. Otherwise `alt_in_o` is 0.
- R10: Alternate bits for pins 0 and 1 always read 0, and those pins stay under GPIO control.
- R11: `wake_o` is 1 exactly when some status bit is set and its matching edge enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| rdata_o | output | NUM_PINS | Read data for `addr_i` (combinational) |
| gpio_i | input | NUM_PINS | Pad input levels |
| gpio_o | output | NUM_PINS | Pad output levels |
| gpio_oe_o | output | NUM_PINS | Pad output enables |
| alt_out_i | input | NUM_PINS | Peripheral output level per pin |
| alt_oe_i | input | NUM_PINS | Peripheral output enable per pin |
| alt_in_o | output | NUM_PINS | Pad input routed to the peripheral |
| wake_o | output | 1 | Enabled-edge wakeup indication |

## Verification
The hardest situation to reach is the hold release itself. The pins must sit at a non-zero level while the hold is set and stay static while it is cleared. Any transition slipping through the mask would show up as a false edge. The bench drives toggling pins under hold first, then parks them at a mixed pattern, clears the hold, and checks both status registers and the level register. Near-exhaustive sweeps then cover all pin patterns for level, direction and set/clear writes.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_LEVEL = 4'd4;
  localparam logic [ADDR_W-1:0] A_REN   = 4'd5;
  localparam logic [ADDR_W-1:0] A_FEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ALT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_RSTAT = 4'd8;
  localparam logic [ADDR_W-1:0] A_FSTAT = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd10;
endpackage

// File: rtl/gpio_sync_chain.sv
`timescale 1ns/1ps
module gpio_sync_chain #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_edge_stat.sv
`timescale 1ns/1ps
module gpio_edge_stat #(
  parameter int W      = 8,
  parameter bit RISING = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic         arm_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] trans, hit, stat_q;

  generate
    if (RISING) begin : g_rise
      assign trans = cur_i & ~prev_i;
    end else begin : g_fall
      assign trans = ~cur_i & prev_i;
    end
  endgenerate

  assign hit = trans & en_i & {W{arm_i}};

  // new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= '0;
    else if (soft_rst_i) stat_q <= '0;
    else                 stat_q <= (stat_q & ~clr_i) | hit;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] alt_sel_i,
  input  logic [W-1:0] alt_out_i,
  input  logic [W-1:0] alt_oe_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] alt_in_o
);
  generate
    for (genvar k = 0; k < W; k++) begin : g_pin
      assign pad_o[k]    = alt_sel_i[k] ? alt_out_i[k] : out_i[k];
      assign pad_oe_o[k] = alt_sel_i[k] ? alt_oe_i[k]  : dir_i[k];
      assign alt_in_o[k] = alt_sel_i[k] & pad_i[k];
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int WAKE_PINS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0] alt_in_o,
  output logic                wake_o
);
  localparam logic [NUM_PINS-1:0] WAKE_MASK =
    {{(NUM_PINS-WAKE_PINS){1'b0}}, {WAKE_PINS{1'b1}}};
  localparam logic [NUM_PINS-1:0] ALT_MASK = ~WAKE_MASK;

  logic [NUM_PINS-1:0] dir_q, out_q, rise_en_q, fall_en_q, alt_q;
  logic                hold_q;
  logic [NUM_PINS-1:0] sync_lvl, prev_lvl, rise_stat, fall_stat;
  logic [NUM_PINS-1:0] rise_clr, fall_clr;

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return wr_en_i && (addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '0;
      out_q     <= '0;
      alt_q     <= '0;
      hold_q    <= 1'b1;
      rise_en_q <= WAKE_MASK;
      fall_en_q <= WAKE_MASK;
    end else if (soft_rst_i) begin
      dir_q     <= '0;
      out_q     <= '0;
      alt_q     <= '0;
      hold_q    <= 1'b1;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (wr_at(A_DIR))  dir_q     <= wdata_i;
      if (wr_at(A_OUT))  out_q     <= wdata_i;
      if (wr_at(A_SET))  out_q     <= out_q | wdata_i;
      if (wr_at(A_CLR))  out_q     <= out_q & ~wdata_i;
      if (wr_at(A_REN))  rise_en_q <= wdata_i;
      if (wr_at(A_FEN))  fall_en_q <= wdata_i;
      if (wr_at(A_ALT))  alt_q     <= wdata_i & ALT_MASK;
      if (wr_at(A_CTRL)) hold_q    <= wdata_i[0];
    end
  end

  assign rise_clr = wr_at(A_RSTAT) ? wdata_i : '0;
  assign fall_clr = wr_at(A_FSTAT) ? wdata_i : '0;

  // chain keeps sampling under hold so release sees no stale transition
  gpio_sync_chain #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(gpio_i),
    .sync_o(sync_lvl), .prev_o(prev_lvl)
  );

  gpio_edge_stat #(.W(NUM_PINS), .RISING(1'b1)) u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .cur_i(sync_lvl), .prev_i(prev_lvl), .arm_i(~hold_q),
    .en_i(rise_en_q), .clr_i(rise_clr), .stat_o(rise_stat)
  );

  gpio_edge_stat #(.W(NUM_PINS), .RISING(1'b0)) u_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .cur_i(sync_lvl), .prev_i(prev_lvl), .arm_i(~hold_q),
    .en_i(fall_en_q), .clr_i(fall_clr), .stat_o(fall_stat)
  );

  gpio_pin_mux #(.W(NUM_PINS)) u_mux (
    .dir_i(dir_q), .out_i(out_q), .alt_sel_i(alt_q),
    .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i), .pad_i(gpio_i),
    .pad_o(gpio_o), .pad_oe_o(gpio_oe_o), .alt_in_o(alt_in_o)
  );

  assign wake_o = |((rise_stat & rise_en_q) | (fall_stat & fall_en_q));

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DIR:   rdata_o = dir_q;
      A_OUT,
      A_SET,
      A_CLR:   rdata_o = out_q;
      A_LEVEL: rdata_o = hold_q ? '0 : sync_lvl;
      A_REN:   rdata_o = rise_en_q;
      A_FEN:   rdata_o = fall_en_q;
      A_ALT:   rdata_o = alt_q;
      A_RSTAT: rdata_o = rise_stat;
      A_FSTAT: rdata_o = fall_stat;
      A_CTRL:  rdata_o[0] = hold_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                soft_rst_i,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic                hold_q,
  input logic [NUM_PINS-1:0] rise_stat,
  input logic [NUM_PINS-1:0] fall_stat,
  input logic                wake_o
);
  p_level_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && addr_i == A_LEVEL) |-> rdata_o == '0);

  p_soft_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (hold_q && gpio_oe_o == '0 && rise_stat == '0 && fall_stat == '0));

  p_no_edge_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> ((rise_stat & ~$past(rise_stat)) == '0 &&
                (fall_stat & ~$past(fall_stat)) == '0));

  p_sticky_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !soft_rst_i) |=> (rise_stat & $past(rise_stat)) == $past(rise_stat));

  p_sticky_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !soft_rst_i) |=> (fall_stat & $past(fall_stat)) == $past(fall_stat));

  p_wake_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (rise_stat | fall_stat) != '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .gpio_oe_o(gpio_oe_o), .hold_q(hold_q), .rise_stat(rise_stat),
  .fall_stat(fall_stat), .wake_o(wake_o)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  import gpio_bank_pkg::*;
  localparam int N = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [N-1:0] wdata_i = '0, gpio_i = '0, alt_out_i = '0, alt_oe_i = '0;
  logic [N-1:0] rdata_o, gpio_o, gpio_oe_o, alt_in_o;
  logic wake_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_bank #(.NUM_PINS(N), .WAKE_PINS(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .gpio_i(gpio_i), .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o),
    .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i), .alt_in_o(alt_in_o),
    .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [N-1:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk_i); gpio_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    gpio_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    #1 chk("R1 oe", gpio_oe_o, 8'h00);
    chk("R1 out", gpio_o, 8'h00);
    rd_chk("R1 ctrl", A_CTRL, 8'h01);
    rd_chk("R1 ren", A_REN, 8'h03);
    rd_chk("R1 fen", A_FEN, 8'h03);
    rd_chk("R1 alt", A_ALT, 8'h00);
    rd_chk("R4 level held", A_LEVEL, 8'h00);
    // R8 toggling under hold
    pins(8'h00); pins(8'hFF); pins(8'h00);
    rd_chk("R8 rise held", A_RSTAT, 8'h00);
    rd_chk("R8 fall held", A_FSTAT, 8'h00);
    // R5 release with static pins
    pins(8'h5B);
    wr(A_CTRL, 8'h00);
    repeat (4) @(negedge clk_i);
    rd_chk("R5 rise", A_RSTAT, 8'h00);
    rd_chk("R5 fall", A_FSTAT, 8'h00);
    rd_chk("R4 level", A_LEVEL, 8'h5B);
    // R4 sweep
    for (int v = 0; v < 256; v++) begin
      @(negedge clk_i); gpio_i = v[N-1:0];
      repeat (3) @(negedge clk_i);
      rd_chk("R4 sweep", A_LEVEL, v[N-1:0]);
    end
    // R6 R7 R11
    wr(A_REN, 8'h0F); wr(A_FEN, 8'hF0);
    pins(8'h00);
    wr(A_RSTAT, 8'hFF); wr(A_FSTAT, 8'hFF);
    rd_chk("R6 cleared", A_RSTAT, 8'h00);
    #1 chk("R11 idle", {7'd0, wake_o}, 8'h00);
    pins(8'hFF);
    rd_chk("R6 rise", A_RSTAT, 8'h0F);
    rd_chk("R8 rise only", A_FSTAT, 8'h00);
    #1 chk("R11 wake", {7'd0, wake_o}, 8'h01);
    pins(8'h00);
    rd_chk("R7 fall", A_FSTAT, 8'hF0);
    rd_chk("R6 sticky", A_RSTAT, 8'h0F);
    wr(A_RSTAT, 8'h00);
    rd_chk("R6 zero write", A_RSTAT, 8'h0F);
    wr(A_RSTAT, 8'h05);
    rd_chk("R6 w1c", A_RSTAT, 8'h0A);
    wr(A_FSTAT, 8'hF0);
    rd_chk("R7 w1c", A_FSTAT, 8'h00);
    wr(A_RSTAT, 8'h0A);
    #1 chk("R11 cleared", {7'd0, wake_o}, 8'h00);
    pins(8'h08);
    rd_chk("R6 pin3", A_RSTAT, 8'h08);
    #1 chk("R11 pin3", {7'd0, wake_o}, 8'h01);
    wr(A_REN, 8'h07);
    #1 chk("R11 disabled", {7'd0, wake_o}, 8'h00);
    rd_chk("R11 stat kept", A_RSTAT, 8'h08);
    // R3 direction and set/clear sweep
    for (int v = 0; v < 256; v++) begin
      wr(A_DIR, v[N-1:0]);
      #1 chk("R3 oe", gpio_oe_o, v[N-1:0]);
      wr(A_OUT, 8'hA5);
      wr(A_SET, v[N-1:0]);
      #1 chk("R3 set", gpio_o, 8'hA5 | v[N-1:0]);
      wr(A_CLR, v[N-1:0]);
      #1 chk("R3 clr", gpio_o, (8'hA5 | v[N-1:0]) & ~v[N-1:0]);
    end
    // R9 R10 alternate
    wr(A_DIR, 8'hFF); wr(A_OUT, 8'h00);
    alt_out_i = 8'hFF; alt_oe_i = 8'h00; gpio_i = 8'hAA;
    wr(A_ALT, 8'hFF);
    rd_chk("R10 alt read", A_ALT, 8'hFC);
    #1 chk("R9 out", gpio_o, 8'hFC);
    chk("R9 oe", gpio_oe_o, 8'h03);
    chk("R9 alt_in", alt_in_o, 8'hA8);
    wr(A_ALT, 8'h30);
    #1 chk("R9 partial out", gpio_o, 8'h30);
    chk("R9 partial alt_in", alt_in_o, 8'h20);
    // R2 soft reset
    wr(A_FEN, 8'hFF);
    @(negedge clk_i); soft_rst_i = 1'b1;
    @(negedge clk_i); soft_rst_i = 1'b0;
    rd_chk("R2 ctrl", A_CTRL, 8'h01);
    rd_chk("R2 ren", A_REN, 8'h00);
    rd_chk("R2 fen", A_FEN, 8'h00);
    rd_chk("R2 alt", A_ALT, 8'h00);
    rd_chk("R2 stat", A_RSTAT, 8'h00);
    #1 chk("R2 oe", gpio_oe_o, 8'h00);
    chk("R2 out", gpio_o, 8'h00);
    // R1 hard reset again
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd_chk("R1 ren again", A_REN, 8'h03);
    rd_chk("R1 fen again", A_FEN, 8'h03);
    finish_run();
  end
endmodule